// File: doc/BRIEF.md
# One-Position Programmable Bit Shifter

This block moves a data word by a single bit position toward the most significant end, toward the least significant end, or passes it through unchanged. Three separate select strobes choose the operation, and at most one of them should be high at a time. Each output bit is chosen from one of three sources: the input bit at its own position, the input bit just below it, or the input bit just above it. A bit position left empty by a shift is filled with zero.

The block is purely combinational and has no clock. It suits datapaths that need a cheap single-step normalise or align stage, such as one step of a serial multiplier or a floating-point adjust. An invalid select pattern is never resolved silently. When two or more strobes are high together, an error flag rises and the output is held at zero. When no strobe is high, the output is also zero and the flag stays low.

Top module: `shift1_top`

## Requirements
- R1: With only `passThru` high, `dataOut` equals `dataIn` bit for bit.
- R2: With only `shiftLeft` high, `dataOut[i]` equals `dataIn[i-1]` for every i from 1 to WIDTH-1.
- R3: With only `shiftLeft` high, `dataOut[0]` is 0 whatever the input.
- R4: With only `shiftRight` high, `dataOut[i]` equals `dataIn[i+1]` for every i from 0 to WIDTH-2.
- R5: With only `shiftRight` high, `dataOut[WIDTH-1]` is 0 whatever the input.
- R6: With no strobe high, `dataOut` is all zeros and `selError` is 0.
- R7: With two or three strobes high, `selError` is 1 and `dataOut` is all zeros.
- R8: With exactly one strobe high, `selError` is 0.
- R9: WIDTH is a parameter with a default of 4 and must be at least 2. The behaviour above holds at WIDTH=16 as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | WIDTH | Word to be shifted |
| shiftLeft | input | 1 | Move one place toward the MSB, zero into bit 0 |
| passThru | input | 1 | Pass the word through unchanged |
| shiftRight | input | 1 | Move one place toward the LSB, zero into the MSB |
| dataOut | output | WIDTH | Result word |
| selError | output | 1 | High when more than one strobe is high |

## Verification
The hardest cases to reach are the edge bits. The zero fill must be observed when the bit that is shifted out is a one, and the result must be checked while the select pattern is illegal. At WIDTH=4 the stimulus walks every data value against all eight strobe combinations, so every edge bit and every illegal pattern is covered. At WIDTH=16 the bench draws random words and random strobe patterns from a seeded generator. It adds directed all-ones words and single-one words placed at the MSB and the LSB, so a missing zero fill shows up at the output.

// File: rtl/shift1_pkg.sv
package shift1_pkg;
  // Decoded, mutually exclusive strobes passed from control to datapath
  typedef struct packed {
    logic moveUp;    // toward MSB
    logic keep;      // pass through
    logic moveDown;  // toward LSB
    logic fault;     // illegal select pattern
  } selStrobes_t;
endpackage

// File: rtl/shift1_ctrl.sv
module shift1_ctrl
  import shift1_pkg::*;
(
  input  logic        shiftLeft,
  input  logic        passThru,
  input  logic        shiftRight,
  output selStrobes_t strobes
);
  logic multiSel;

  // any pair high means the pattern is not one-hot
  assign multiSel = (shiftLeft & passThru) | (shiftLeft & shiftRight) |
                    (passThru & shiftRight);

  always_comb begin
    strobes.fault    = multiSel;
    strobes.moveUp   = shiftLeft  & ~multiSel;
    strobes.keep     = passThru   & ~multiSel;
    strobes.moveDown = shiftRight & ~multiSel;
  end
endmodule

// File: rtl/shift1_datapath.sv
module shift1_datapath
  import shift1_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] dataIn,
  input  selStrobes_t      strobes,
  output logic [WIDTH-1:0] dataOut
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;

    if (i == 0) begin : g_lsb
      assign fromBelow = 1'b0;
    end else begin : g_lo
      assign fromBelow = dataIn[i-1];
    end

    if (i == TOP) begin : g_msb
      assign fromAbove = 1'b0;
    end else begin : g_hi
      assign fromAbove = dataIn[i+1];
    end

    // three-way neighbour select, one strobe at most is active
    assign dataOut[i] = (strobes.moveUp   & fromBelow) |
                        (strobes.keep     & dataIn[i]) |
                        (strobes.moveDown & fromAbove);
  end
endmodule

// File: rtl/shift1_top.sv
module shift1_top
  import shift1_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic             shiftLeft,
  input  logic             passThru,
  input  logic             shiftRight,
  output logic [WIDTH-1:0] dataOut,
  output logic             selError
);
  selStrobes_t strobes;

  if (WIDTH < 2) begin : g_bad_width
    $error("shift1_top: WIDTH must be at least 2");
  end

  shift1_ctrl u_ctrl (
    .shiftLeft (shiftLeft),
    .passThru  (passThru),
    .shiftRight(shiftRight),
    .strobes   (strobes)
  );

  shift1_datapath #(.WIDTH(WIDTH)) u_dp (
    .dataIn (dataIn),
    .strobes(strobes),
    .dataOut(dataOut)
  );

  assign selError = strobes.fault;
endmodule

// File: rtl/shift1_chk.sv
module shift1_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] dataIn,
  input logic             shiftLeft,
  input logic             passThru,
  input logic             shiftRight,
  input logic [WIDTH-1:0] dataOut,
  input logic             selError
);
  logic [1:0] selCount;
  assign selCount = 2'(shiftLeft) + 2'(passThru) + 2'(shiftRight);

  always_comb begin
    // R1
    hold_match_chk: assert (!(passThru && selCount == 2'd1) || dataOut == dataIn);
    // R2
    up_body_chk: assert (!(shiftLeft && selCount == 2'd1) ||
                         dataOut[WIDTH-1:1] == dataIn[WIDTH-2:0]);
    // R3
    up_fill_chk: assert (!(shiftLeft && selCount == 2'd1) || !dataOut[0]);
    // R4
    down_body_chk: assert (!(shiftRight && selCount == 2'd1) ||
                           dataOut[WIDTH-2:0] == dataIn[WIDTH-1:1]);
    // R5
    down_fill_chk: assert (!(shiftRight && selCount == 2'd1) || !dataOut[WIDTH-1]);
    // R6
    idle_zero_chk: assert (selCount != 2'd0 || (dataOut == '0 && !selError));
    // R7
    multi_sel_chk: assert (selCount < 2'd2 || (selError && dataOut == '0));
    // R8
    single_sel_chk: assert (selCount != 2'd1 || !selError);
  end
endmodule

bind shift1_top shift1_chk #(.WIDTH(WIDTH)) u_chk (
  .dataIn    (dataIn),
  .shiftLeft (shiftLeft),
  .passThru  (passThru),
  .shiftRight(shiftRight),
  .dataOut   (dataOut),
  .selError  (selError)
);

// File: tb/shift1_top_tb.sv
module shift1_top_tb;
  localparam int NARROW = 4;
  localparam int WIDE   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int errors = 0;
  int checks = 0;

  logic [NARROW-1:0] inN, outN;
  logic [WIDE-1:0]   inW, outW;
  logic lN, hN, rN, eN, lW, hW, rW, eW;

  shift1_top #(.WIDTH(NARROW)) u_dut (
    .dataIn(inN), .shiftLeft(lN), .passThru(hN), .shiftRight(rN),
    .dataOut(outN), .selError(eN));

  shift1_top #(.WIDTH(WIDE)) u_dutWide (
    .dataIn(inW), .shiftLeft(lW), .passThru(hW), .shiftRight(rW),
    .dataOut(outW), .selError(eW));

  function automatic logic [WIDE-1:0] refShift(input logic [WIDE-1:0] d, input int w,
                                               input logic l, input logic h, input logic r);
    int n = int'(l) + int'(h) + int'(r);
    logic [WIDE-1:0] res = '0;
    if (n != 1) return '0;
    for (int i = 0; i < w; i++) begin
      if (h) res[i] = d[i];
      else if (l) res[i] = (i == 0) ? 1'b0 : d[i-1];
      else res[i] = (i == w-1) ? 1'b0 : d[i+1];
    end
    return res;
  endfunction

  function automatic string reqTag(input logic l, input logic h, input logic r, input int w);
    int n = int'(l) + int'(h) + int'(r);
    string s;
    if (n == 0) s = "R6";
    else if (n > 1) s = "R7";
    else if (h) s = "R1";
    else if (l) s = "R2/R3";
    else s = "R4/R5";
    if (w == WIDE) s = {s, " R9"};
    return s;
  endfunction

  task automatic checkNarrow();
    logic [NARROW-1:0] expD;
    logic expE;
    expD = refShift(WIDE'(inN), NARROW, lN, hN, rN);
    expE = (int'(lN) + int'(hN) + int'(rN)) > 1;
    checks++;
    if (outN !== expD) begin
      errors++;
      $display("FAIL %s data in=%h sel=%b%b%b actual=%h expected=%h",
               reqTag(lN, hN, rN, NARROW), inN, lN, hN, rN, outN, expD);
    end
    checks++;
    if (eN !== expE) begin
      errors++;
      $display("FAIL R7/R8 flag sel=%b%b%b actual=%b expected=%b", lN, hN, rN, eN, expE);
    end
  endtask

  task automatic checkWide();
    logic [WIDE-1:0] expD;
    logic expE;
    expD = refShift(inW, WIDE, lW, hW, rW);
    expE = (int'(lW) + int'(hW) + int'(rW)) > 1;
    checks++;
    if (outW !== expD) begin
      errors++;
      $display("FAIL %s data in=%h sel=%b%b%b actual=%h expected=%h",
               reqTag(lW, hW, rW, WIDE), inW, lW, hW, rW, outW, expD);
    end
    checks++;
    if (eW !== expE) begin
      errors++;
      $display("FAIL R7/R8 R9 flag sel=%b%b%b actual=%b expected=%b", lW, hW, rW, eW, expE);
    end
  endtask

  task automatic applyWide(input logic [WIDE-1:0] d, input logic [2:0] s);
    @(posedge clk);
    inW = d; {lW, hW, rW} = s;
    @(negedge clk);
    checkWide();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    inN = '0; inW = '0;
    {lN, hN, rN} = 3'b000; {lW, hW, rW} = 3'b000;
    // reset-like idle state: no strobe, output zero (R6)
    @(negedge clk);
    checkNarrow();
    checkWide();

    // exhaustive narrow sweep: R1..R8
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < (1 << NARROW); d++) begin
        @(posedge clk);
        inN = NARROW'(d); {lN, hN, rN} = 3'(s);
        @(negedge clk);
        checkNarrow();
      end
    end

    // directed wide corners: edge fill R3, R5 with ones at the edges, R9
    for (int s = 0; s < 8; s++) begin
      applyWide('1, 3'(s));
      applyWide(16'h8000, 3'(s));
      applyWide(16'h0001, 3'(s));
    end

    // seeded random wide stimulus, R9
    void'($urandom(32'h1d2c3b4a));
    for (int k = 0; k < 400; k++) begin
      logic [2:0] sel;
      sel = ($urandom % 4 == 0) ? 3'($urandom) : (3'b001 << ($urandom % 3));
      applyWide(16'($urandom), sel);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule